// File: doc/BRIEF.md
# UART Receive Line Noise Filter

This block cleans the receive-data line of a serial port before the receiver sees it. It makes its own sampling strobe, at sixteen times the bit rate, as a one-cycle enable on the system clock. The strobe starts from a selectable source tick, which is either the system clock, the system clock divided by 8 or by 32, rising edges of a slow sub-clock input, or rising edges of an external serial clock input. The source tick is then divided by a programmable value plus one.

On each strobe the synchronized receive level moves into a chain of three sampling registers. The filtered output takes the level the three registers hold only when all three agree. Otherwise it keeps its last value. A level change that does not last for three strobes never reaches the output. This is a unanimous match and not a majority vote. When filtering is turned off, the synchronized raw line goes straight to the output. The receiver that consumes the output is a separate block.

Top module: `rxd_glitch_filter`

## Requirements
- R1: While reset is asserted and after it, until the input says otherwise, the output `rxd_int` is high (line idle), whether filtering is on or off, and all three sampling registers hold high.
- R2: The raw receive line, the sub-clock and the external clock each pass through a two-register synchronizer. With filtering off, a change on `rxd_raw` shows at `rxd_int` after exactly two rising edges of `clk`.
- R3: Source tick selection: with `use_ext`=1 the tick is each rising edge of the synchronized `ext_sclk`. With `use_ext`=0, `int_src` picks the tick: 0 gives every cycle, 1 gives one cycle in 8, 2 gives one cycle in 32 (both counted from reset), and 3 gives each rising edge of the synchronized `lsclk`.
- R4: A sample strobe occurs on every (`divisor`+1)-th source tick. With `divisor`=0, every source tick is a strobe.
- R5: On each strobe the three sampling registers shift by one place, taking in the synchronized receive level. Between strobes they hold their values.
- R6: When all three sampling registers hold the same level, the filtered output takes that level on the next clock edge.
- R7: When the three sampling registers do not all agree, the filtered output holds its value. As a result, a pulse seen by fewer than three consecutive strobes never appears at `rxd_int`.
- R8: With `filt_en`=0, `rxd_int` follows the synchronized raw line and ignores the filter state. With `filt_en`=1, it shows the filtered level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd_raw | input | 1 | Raw receive line, asynchronous |
| lsclk | input | 1 | Slow sub-clock, asynchronous, used as a tick source |
| ext_sclk | input | 1 | External serial clock, asynchronous |
| use_ext | input | 1 | 1 selects the external clock as the tick source |
| int_src | input | 2 | Internal tick source: 0 full, 1 /8, 2 /32, 3 sub-clock |
| divisor | input | DIV_W | Strobe divider value n; the strobe rate is the tick rate/(n+1) |
| filt_en | input | 1 | 1 enables the noise filter, 0 bypasses it |
| rxd_int | output | 1 | Filtered (or bypassed) receive line |

## Verification
If the strobe divider or the prescaler holds the wrong count, the filtered output's falling and rising edges land one or more strobes early or late. A per-cycle reference comparison catches this at the first data transition after the fault. If the three-register chain shifts without a strobe, or the output takes a level on a mismatch, a short pulse leaks through to `rxd_int` within three strobes of the pulse. Each tick source and the bypass path get their own stimulus phase, so a wrong source selection shows as timing divergence within one source period.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [1:0] {
        SRC_FULL  = 2'd0,
        SRC_SLOWA = 2'd1,
        SRC_SLOWB = 2'd2,
        SRC_SUB   = 2'd3
    } int_src_e;

    typedef struct packed {
        logic s2;
        logic s1;
        logic s0;
    } smp_t;

    localparam logic IDLE_LEVEL = 1'b1;

    function automatic logic all_agree(input smp_t s);
        return (s.s0 == s.s1) && (s.s1 == s.s2);
    endfunction

    function automatic smp_t smp_shift(input smp_t s, input logic din);
        smp_t r;
        r.s2 = s.s1;
        r.s1 = s.s0;
        r.s0 = din;
        return r;
    endfunction

endpackage

// File: rtl/rxf_sync.sv
module rxf_sync #(
    parameter int unsigned W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_r;
    logic [W-1:0] q_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_r <= RST_VAL;
            q_r    <= RST_VAL;
        end else begin
            meta_r <= d;
            q_r    <= meta_r;
        end
    end

    assign q = q_r;
endmodule

// File: rtl/rxf_tick_src.sv
module rxf_tick_src
    import rxf_pkg::*;
#(
    parameter int unsigned PRE_A_LOG2 = 3,
    parameter int unsigned PRE_B_LOG2 = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sub_s,
    input  logic       ext_s,
    input  logic       use_ext,
    input  logic [1:0] int_src,
    output logic       src_tick
);
    localparam int unsigned PRE_W = PRE_B_LOG2;

    logic [PRE_W-1:0] pre_cnt;
    logic             sub_d;
    logic             ext_d;
    logic             tick_a;
    logic             tick_b;
    logic             sub_rise;
    logic             ext_rise;
    logic             int_tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_cnt <= '0;
            sub_d   <= 1'b0;
            ext_d   <= 1'b0;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
            sub_d   <= sub_s;
            ext_d   <= ext_s;
        end
    end

    assign tick_a   = &pre_cnt[PRE_A_LOG2-1:0];
    assign tick_b   = &pre_cnt;
    assign sub_rise = sub_s & ~sub_d;
    assign ext_rise = ext_s & ~ext_d;

    always_comb begin
        unique case (int_src_e'(int_src))
            SRC_FULL:  int_tick = 1'b1;
            SRC_SLOWA: int_tick = tick_a;
            SRC_SLOWB: int_tick = tick_b;
            SRC_SUB:   int_tick = sub_rise;
            default:   int_tick = 1'b0;
        endcase
    end

    assign src_tick = use_ext ? ext_rise : int_tick;

    AST_SLOWA_SPACED: assert property (@(posedge clk) disable iff (rst)
        tick_a |=> !tick_a); // R3
    AST_EXT_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        (use_ext && src_tick) |=> !(use_ext && src_tick)); // R3
endmodule

// File: rtl/rxf_strobe_div.sv
module rxf_strobe_div #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             src_tick,
    input  logic [DIV_W-1:0] divisor,
    output logic             sample_en
);
    logic [DIV_W-1:0] cnt;
    logic             wrap;

    assign wrap      = (cnt >= divisor);
    assign sample_en = src_tick & wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (src_tick) begin
            cnt <= wrap ? '0 : cnt + 1'b1;
        end
    end

    AST_DIV_ZERO_EVERY_TICK: assert property (@(posedge clk) disable iff (rst)
        (src_tick && divisor == '0) |-> sample_en); // R4
    AST_STROBE_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        (sample_en && divisor != '0) |=> !(src_tick && $stable(divisor) && sample_en)); // R4
endmodule

// File: rtl/rxf_match.sv
module rxf_match
    import rxf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sample_en,
    input  logic din,
    output logic dout
);
    smp_t smp;
    logic filt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            smp    <= '{s2: IDLE_LEVEL, s1: IDLE_LEVEL, s0: IDLE_LEVEL};
            filt_q <= IDLE_LEVEL;
        end else begin
            if (sample_en) begin
                smp <= smp_shift(smp, din);
            end
            if (all_agree(smp)) begin
                filt_q <= smp.s0;
            end
        end
    end

    assign dout = filt_q;

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> $stable(smp)); // R5
    AST_MATCH_FORWARD: assert property (@(posedge clk) disable iff (rst)
        all_agree(smp) |=> (dout == $past(smp.s0))); // R6
    AST_MISMATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        !all_agree(smp) |=> $stable(dout)); // R7
endmodule

// File: rtl/rxd_glitch_filter.sv
module rxd_glitch_filter
    import rxf_pkg::*;
#(
    parameter int unsigned DIV_W      = 8,
    parameter int unsigned PRE_A_LOG2 = 3,
    parameter int unsigned PRE_B_LOG2 = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rxd_raw,
    input  logic             lsclk,
    input  logic             ext_sclk,
    input  logic             use_ext,
    input  logic [1:0]       int_src,
    input  logic [DIV_W-1:0] divisor,
    input  logic             filt_en,
    output logic             rxd_int
);
    logic       rxd_s;
    logic [1:0] clk_s;
    logic       src_tick;
    logic       sample_en;
    logic       filt_out;

    rxf_sync #(.W(1), .RST_VAL(IDLE_LEVEL)) u_rxd_sync (
        .clk (clk),
        .rst (rst),
        .d   (rxd_raw),
        .q   (rxd_s)
    );

    rxf_sync #(.W(2), .RST_VAL(2'b00)) u_clk_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ext_sclk, lsclk}),
        .q   (clk_s)
    );

    rxf_tick_src #(.PRE_A_LOG2(PRE_A_LOG2), .PRE_B_LOG2(PRE_B_LOG2)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .sub_s    (clk_s[0]),
        .ext_s    (clk_s[1]),
        .use_ext  (use_ext),
        .int_src  (int_src),
        .src_tick (src_tick)
    );

    rxf_strobe_div #(.DIV_W(DIV_W)) u_div (
        .clk       (clk),
        .rst       (rst),
        .src_tick  (src_tick),
        .divisor   (divisor),
        .sample_en (sample_en)
    );

    rxf_match u_match (
        .clk       (clk),
        .rst       (rst),
        .sample_en (sample_en),
        .din       (rxd_s),
        .dout      (filt_out)
    );

    assign rxd_int = filt_en ? filt_out : rxd_s;

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
        $fell(rst) |-> rxd_int == IDLE_LEVEL); // R1
endmodule

// File: tb/rxd_glitch_filter_tb.sv
module rxd_glitch_filter_tb;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             rxd_raw = 1'b1;
    logic             lsclk = 1'b0;
    logic             ext_sclk = 1'b0;
    logic             use_ext = 1'b0;
    logic [1:0]       int_src = 2'd0;
    logic [DIV_W-1:0] divisor = '0;
    logic             filt_en = 1'b1;
    logic             rxd_int;

    int checks = 0;
    int errors = 0;
    int cyc_total = 0;
    string tag = "R1";
    bit cmp_on = 1'b0;
    bit saw_low = 1'b0;

    always #2 clk = ~clk;

    rxd_glitch_filter #(.DIV_W(DIV_W)) u_dut (
        .clk(clk), .rst(rst), .rxd_raw(rxd_raw), .lsclk(lsclk),
        .ext_sclk(ext_sclk), .use_ext(use_ext), .int_src(int_src),
        .divisor(divisor), .filt_en(filt_en), .rxd_int(rxd_int)
    );

    // behavioural reference: delay queues and integer counters
    bit rx_q[$];
    bit sub_q[$];
    bit ext_q[$];
    bit smp_q[$];
    int pre_n, div_n;
    bit m_filt;

    function automatic bit exp_out();
        return filt_en ? m_filt : rx_q[1];
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            rx_q = '{1'b1, 1'b1};
            sub_q = '{1'b0, 1'b0, 1'b0};
            ext_q = '{1'b0, 1'b0, 1'b0};
            smp_q = '{1'b1, 1'b1, 1'b1};
            pre_n = 0; div_n = 0; m_filt = 1'b1;
        end else begin
            bit tick, strobe;
            if (use_ext) tick = ext_q[1] && !ext_q[2];
            else case (int_src)
                2'd0: tick = 1'b1;
                2'd1: tick = (pre_n % 8) == 7;
                2'd2: tick = (pre_n % 32) == 31;
                default: tick = sub_q[1] && !sub_q[2];
            endcase
            strobe = tick && (div_n >= int'(divisor));
            if (smp_q[0] == smp_q[1] && smp_q[1] == smp_q[2]) m_filt = smp_q[0];
            if (strobe) begin
                smp_q.push_front(rx_q[1]);
                void'(smp_q.pop_back());
            end
            if (tick) div_n = (div_n >= int'(divisor)) ? 0 : div_n + 1;
            rx_q.push_front(rxd_raw);   void'(rx_q.pop_back());
            sub_q.push_front(lsclk);    void'(sub_q.pop_back());
            ext_q.push_front(ext_sclk); void'(ext_q.pop_back());
            pre_n = (pre_n + 1) % 32;
        end
    end

    task automatic check(input string req, input bit got, input bit exp, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %b exp %b", req, what, got, exp);
        end
    endtask

    // one cycle: wait for the falling edge, compare with the model, track lows
    task automatic step();
        @(negedge clk);
        if (cmp_on) check(tag, rxd_int, exp_out(), "per-cycle rxd_int");
        if (rxd_int === 1'b0) saw_low = 1'b1;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic pulse_low(input int len);
        rxd_raw = 1'b0; steps(len);
        rxd_raw = 1'b1;
    endtask

    // random line with slow clocks toggled at fixed periods
    task automatic random_run(input int n, input int ls_per, input int ex_per);
        for (int i = 0; i < n; i++) begin
            if (i % ls_per == 0) lsclk = ~lsclk;
            if (i % ex_per == 0) ext_sclk = ~ext_sclk;
            if ($urandom_range(0, 5) == 0) rxd_raw = ~rxd_raw;
            step();
        end
    endtask

    initial begin
        steps(4);
        tag = "R1";
        check("R1", rxd_int, 1'b1, "idle during reset, filter on");
        filt_en = 1'b0; step();
        check("R1", rxd_int, 1'b1, "idle during reset, bypass");
        filt_en = 1'b1;
        rst = 1'b0; cmp_on = 1'b1;
        step();
        check("R1", rxd_int, 1'b1, "idle after reset");
        steps(10);

        // R2 / R8: bypass latency of two edges
        tag = "R8"; filt_en = 1'b0; steps(2);
        rxd_raw = 1'b0; step();
        check("R2", rxd_int, 1'b1, "bypass after one edge");
        step();
        check("R2", rxd_int, 1'b0, "bypass after two edges");
        rxd_raw = 1'b1; steps(3);
        check("R8", rxd_int, 1'b1, "bypass follows line back high");

        // R7 / R6: strobe every 4 cycles
        tag = "R7"; filt_en = 1'b1; int_src = 2'd0; divisor = 8'd3;
        steps(40); saw_low = 1'b0;
        pulse_low(5); steps(40);
        check("R7", saw_low, 1'b0, "5-cycle pulse at 4-cycle strobe rejected");
        tag = "R6"; saw_low = 1'b0;
        pulse_low(16); steps(40);
        check("R6", saw_low, 1'b1, "16-cycle pulse at 4-cycle strobe accepted");
        check("R6", rxd_int, 1'b1, "returns high after long pulse");

        // R4: divisor 0 strobes every tick
        tag = "R4"; divisor = 8'd0; steps(10); saw_low = 1'b0;
        pulse_low(2); steps(10);
        check("R4", saw_low, 1'b0, "2-cycle pulse rejected at full rate");
        saw_low = 1'b0;
        pulse_low(3); steps(10);
        check("R4", saw_low, 1'b1, "3-cycle pulse accepted at full rate");

        // R8: filter state ignored in bypass, restored on enable
        tag = "R8"; filt_en = 1'b0; rxd_raw = 1'b0; steps(3);
        check("R8", rxd_int, 1'b0, "bypass shows low line");
        filt_en = 1'b1; divisor = 8'd200; int_src = 2'd2; step();
        check("R8", rxd_int, 1'b1, "filtered output kept its high level");
        rxd_raw = 1'b1; divisor = 8'd0; steps(200);

        // R3 / R5: every source, random data
        tag = "R3"; int_src = 2'd1; divisor = 8'd0; random_run(1500, 5, 3);
        tag = "R5"; int_src = 2'd2; divisor = 8'd1; random_run(3000, 5, 3);
        tag = "R3"; int_src = 2'd3; divisor = 8'd2; random_run(1500, 4, 3);
        tag = "R3"; use_ext = 1'b1; divisor = 8'd1; random_run(1500, 4, 3);
        tag = "R5"; use_ext = 1'b0; int_src = 2'd0; divisor = 8'd5; random_run(1500, 4, 3);
        tag = "R7"; filt_en = 1'b0; random_run(300, 4, 3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 100000) begin
            errors++;
            $display("FAIL watchdog expired got running exp finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule